// File: doc/BRIEF.md
# Event Link Monitor with Timestamp Capture

This block sits on a received event link and sees every event code that arrives. A free-running counter in the block supplies a timestamp for each event. A per-code enable mask decides which events are kept. Kept events are written into an on-chip circular buffer as records of code and timestamp. A reader takes the records out oldest first through a show-ahead read port.

Software may arm one event code as a reference. Each time that code arrives, its timestamp is latched, and the event is kept even when its mask bit is clear. Every record presented at the read port also carries a signed offset: the record's timestamp minus the latched timestamp of the most recent reference. The reference record therefore shows zero, records older than it show negative values and records newer than it show positive values. Records that find the buffer full are dropped and counted.

Top module: `evmon_top`

## Requirements
- R1: After reset the buffer is empty (`rd_valid_o` low), `ovf_cnt_o` is 0, `ref_seen_o` is 0, every mask bit is clear, the reference is disarmed and the timestamp counter is 0.
- R2: The timestamp counter adds one on every clock edge and wraps modulo 2^TS_W. An event sampled at an edge is stamped with the counter value from before that edge's increment.
- R3: A pulse on `mask_we_i` sets the mask bit selected by `mask_code_i` to `mask_bit_i`. An event with `ev_valid_i` high is stored only if the mask bit for its code is 1 or it is a reference hit. Otherwise it leaves the buffer unchanged.
- R4: A pulse on `ref_we_i` loads the reference code from `ref_code_i` and the arm bit from `ref_en_i`. It also clears `ref_seen_o` and clears the latched reference time to 0. An event whose code equals the armed reference code latches its timestamp, sets `ref_seen_o` and is stored whatever its mask bit holds. A `ref_we_i` pulse in the same cycle takes priority over the latch.
- R5: The read port shows the oldest record while `rd_valid_o` is high. `rd_en_i` with `rd_valid_o` high removes that record. `rd_en_i` while the buffer is empty has no effect.
- R6: `rd_ofs_o` equals `rd_ts_o` minus the latched reference time, modulo 2^TS_W, read as two's complement. This is 0 for the reference record, negative for earlier records and positive for later ones. The value is correct across a counter wrap. While no reference has been seen, the offset equals the timestamp.
- R7: The buffer holds DEPTH records. An event that would be stored while the buffer holds DEPTH records is dropped, even if a read removes a record in the same cycle. Each drop adds one to `ovf_cnt_o`, which saturates at its all-ones value.
- R8: Stored records come out in arrival order, including events on consecutive cycles, with their codes and timestamps intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Event link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | An event code is present this cycle |
| ev_code_i | input | CODE_W | Received event code |
| mask_we_i | input | 1 | Write one mask bit |
| mask_code_i | input | CODE_W | Code whose mask bit is written |
| mask_bit_i | input | 1 | New mask bit value |
| ref_we_i | input | 1 | Load reference selection |
| ref_code_i | input | CODE_W | Reference event code |
| ref_en_i | input | 1 | Arm the reference |
| rd_en_i | input | 1 | Remove the record shown |
| rd_valid_o | output | 1 | A record is shown |
| rd_code_o | output | CODE_W | Code of the shown record |
| rd_ts_o | output | TS_W | Absolute timestamp of the shown record |
| rd_ofs_o | output | TS_W | Signed offset from the latest reference |
| ref_seen_o | output | 1 | Reference latched since last selection |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped records |

## Verification
The bench builds the block with TS_W=12, DEPTH=8 and OVF_W=4. The 12-bit counter wraps after 4096 cycles, so a reference taken just before the wrap and an event just after it can be checked for correct signed offsets. An 8-entry buffer fills after a few events, which brings the drop rule and a drop in the same cycle as a read within reach. A 4-bit drop counter reaches saturation after 15 drops. The code width keeps its default of 8, so the full 256-entry mask and the codes 0x00 and 0xFF are covered.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned TS_W_DEF   = 32;
  localparam int unsigned DEPTH_DEF  = 512;
  localparam int unsigned OVF_W_DEF  = 16;
endpackage

// File: rtl/evmon_tsc.sv
module evmon_tsc #(
  parameter int unsigned TS_W = evmon_pkg::TS_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/evmon_filter.sv
module evmon_filter #(
  parameter int unsigned CODE_W = evmon_pkg::CODE_W_DEF,
  parameter int unsigned TS_W   = evmon_pkg::TS_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [CODE_W-1:0] ev_code_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              mask_we_i,
  input  logic [CODE_W-1:0] mask_code_i,
  input  logic              mask_bit_i,
  input  logic              ref_we_i,
  input  logic [CODE_W-1:0] ref_code_i,
  input  logic              ref_en_i,
  output logic              store_o,
  output logic              ref_hit_o,
  output logic              ref_seen_o,
  output logic [TS_W-1:0]   ref_ts_o
);
  localparam int unsigned NCODES = 1 << CODE_W;

  logic [NCODES-1:0] mask_q;
  logic [CODE_W-1:0] ref_code_q;
  logic              ref_en_q;

  for (genvar g = 0; g < NCODES; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          mask_q[g] <= 1'b0;
      else if (mask_we_i && (mask_code_i == CODE_W'(g)))    mask_q[g] <= mask_bit_i;
    end
  end

  assign ref_hit_o = ev_valid_i && ref_en_q && (ev_code_i == ref_code_q);
  assign store_o   = ev_valid_i && (mask_q[ev_code_i] || ref_hit_o);

  // selection write wins over a same-cycle latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_code_q <= '0;
      ref_en_q   <= 1'b0;
      ref_seen_o <= 1'b0;
      ref_ts_o   <= '0;
    end else if (ref_we_i) begin
      ref_code_q <= ref_code_i;
      ref_en_q   <= ref_en_i;
      ref_seen_o <= 1'b0;
      ref_ts_o   <= '0;
    end else if (ref_hit_o) begin
      ref_seen_o <= 1'b1;
      ref_ts_o   <= ts_i;
    end
  end
endmodule

// File: rtl/evmon_fifo.sv
module evmon_fifo #(
  parameter int unsigned DATA_W = 40,
  parameter int unsigned DEPTH  = evmon_pkg::DEPTH_DEF,
  parameter int unsigned OVF_W  = evmon_pkg::OVF_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              drop_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic              full, wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_q == CW'(DEPTH));
  assign valid_o = (count_q != '0);
  assign wr_ok   = push_i && !full;
  assign rd_ok   = pop_i && valid_o;
  assign drop_o  = push_i && full;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      ovf_cnt_o <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (drop_o && (ovf_cnt_o != '1)) ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/evmon_top.sv
module evmon_top #(
  parameter int unsigned CODE_W = evmon_pkg::CODE_W_DEF,
  parameter int unsigned TS_W   = evmon_pkg::TS_W_DEF,
  parameter int unsigned DEPTH  = evmon_pkg::DEPTH_DEF,
  parameter int unsigned OVF_W  = evmon_pkg::OVF_W_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ev_valid_i,
  input  logic [CODE_W-1:0]      ev_code_i,
  input  logic                   mask_we_i,
  input  logic [CODE_W-1:0]      mask_code_i,
  input  logic                   mask_bit_i,
  input  logic                   ref_we_i,
  input  logic [CODE_W-1:0]      ref_code_i,
  input  logic                   ref_en_i,
  input  logic                   rd_en_i,
  output logic                   rd_valid_o,
  output logic [CODE_W-1:0]      rd_code_o,
  output logic [TS_W-1:0]        rd_ts_o,
  output logic signed [TS_W-1:0] rd_ofs_o,
  output logic                   ref_seen_o,
  output logic [OVF_W-1:0]       ovf_cnt_o
);
  localparam int unsigned REC_W = CODE_W + TS_W;

  logic [TS_W-1:0]  ts;
  logic [TS_W-1:0]  ref_ts;
  logic             store, ref_hit, drop;
  logic [REC_W-1:0] rec_in, rec_out;

  evmon_tsc #(.TS_W(TS_W)) i_tsc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts)
  );

  evmon_filter #(.CODE_W(CODE_W), .TS_W(TS_W)) i_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_valid_i (ev_valid_i),
    .ev_code_i  (ev_code_i),
    .ts_i       (ts),
    .mask_we_i  (mask_we_i),
    .mask_code_i(mask_code_i),
    .mask_bit_i (mask_bit_i),
    .ref_we_i   (ref_we_i),
    .ref_code_i (ref_code_i),
    .ref_en_i   (ref_en_i),
    .store_o    (store),
    .ref_hit_o  (ref_hit),
    .ref_seen_o (ref_seen_o),
    .ref_ts_o   (ref_ts)
  );

  assign rec_in = {ev_code_i, ts};

  evmon_fifo #(.DATA_W(REC_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) i_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (store),
    .data_i   (rec_in),
    .pop_i    (rd_en_i),
    .valid_o  (rd_valid_o),
    .data_o   (rec_out),
    .drop_o   (drop),
    .ovf_cnt_o(ovf_cnt_o)
  );

  assign rd_code_o = rec_out[REC_W-1:TS_W];
  assign rd_ts_o   = rec_out[TS_W-1:0];
  // modular difference gives correct sign across counter wrap
  assign rd_ofs_o  = $signed(rd_ts_o - ref_ts);
endmodule

// File: rtl/evmon_checker.sv
module evmon_checker #(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned OVF_W = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ev_valid_i,
  input logic             ref_we_i,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic             store_i,
  input logic             ref_hit_i,
  input logic             ref_seen_i,
  input logic [TS_W-1:0]  ref_ts_i,
  input logic [TS_W-1:0]  ts_i,
  input logic [CW-1:0]    count_i,
  input logic             drop_i,
  input logic [OVF_W-1:0] ovf_i
);
  a_r2_ts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ts_i == TS_W'($past(ts_i) + 1'b1));

  a_r3_filtered_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !store_i) |=> count_i <= $past(count_i));

  a_r4_ref_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_hit_i && !ref_we_i) |=> (ref_seen_i && ref_ts_i == $past(ts_i)));

  a_r5_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_valid_o && !store_i) |=> count_i == $past(count_i) - 1'b1);

  a_r7_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CW'(DEPTH) && store_i && !(rd_en_i && rd_valid_o)) |=> count_i == CW'(DEPTH));

  a_r7_ovf_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> (ovf_i == OVF_W'($past(ovf_i) + 1'b1) || $past(ovf_i) == '1));

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));
endmodule

bind evmon_top evmon_checker #(.TS_W(TS_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ev_valid_i(ev_valid_i),
  .ref_we_i  (ref_we_i),
  .rd_en_i   (rd_en_i),
  .rd_valid_o(rd_valid_o),
  .store_i   (store),
  .ref_hit_i (ref_hit),
  .ref_seen_i(ref_seen_o),
  .ref_ts_i  (ref_ts),
  .ts_i      (ts),
  .count_i   (i_fifo.count_q),
  .drop_i    (drop),
  .ovf_i     (ovf_cnt_o)
);

// File: tb/test_evmon_top.sv
`timescale 1ns/1ps
module test_evmon_top;
  localparam int CODE_W = 8;
  localparam int TS_W   = 12;
  localparam int DEPTH  = 8;
  localparam int OVF_W  = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ev_valid_i = 0, mask_we_i = 0, mask_bit_i = 0, ref_we_i = 0, ref_en_i = 0, rd_en_i = 0;
  logic [CODE_W-1:0] ev_code_i = '0, mask_code_i = '0, ref_code_i = '0;
  logic rd_valid_o, ref_seen_o;
  logic [CODE_W-1:0] rd_code_o;
  logic [TS_W-1:0] rd_ts_o;
  logic signed [TS_W-1:0] rd_ofs_o;
  logic [OVF_W-1:0] ovf_cnt_o;

  evmon_top #(.CODE_W(CODE_W), .TS_W(TS_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) i_evmon_top (.*);

  always #5 clk_i = ~clk_i;

  // bench time model: edges since reset release, modulo 2^TS_W
  logic [TS_W-1:0] tcyc;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tcyc <= '0; else tcyc <= tcyc + 1'b1;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [CODE_W-1:0] q_code [32];
  logic [TS_W-1:0]   q_ts [32];
  int q_n = 0, q_h = 0;
  logic [TS_W-1:0] ref_exp = '0;
  logic [TS_W-1:0] last_ts;

  // {code, gap, stored, is_ref, pad}
  localparam logic [15:0] VEC [8] = '{
    {8'h10, 4'd0, 1'b1, 1'b0, 2'b0},
    {8'h44, 4'd2, 1'b0, 1'b0, 2'b0},
    {8'h33, 4'd1, 1'b1, 1'b1, 2'b0},
    {8'h20, 4'd0, 1'b1, 1'b0, 2'b0},
    {8'hFF, 4'd3, 1'b1, 1'b0, 2'b0},
    {8'h33, 4'd5, 1'b1, 1'b1, 2'b0},
    {8'h00, 4'd1, 1'b1, 1'b0, 2'b0},
    {8'h55, 4'd0, 1'b0, 1'b0, 2'b0}
  };

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [CODE_W-1:0] c);
    ev_valid_i = 1; ev_code_i = c; last_ts = tcyc;
    @(negedge clk_i);
    ev_valid_i = 0;
  endtask

  task automatic set_mask(input logic [CODE_W-1:0] c, input logic b);
    mask_we_i = 1; mask_code_i = c; mask_bit_i = b;
    @(negedge clk_i);
    mask_we_i = 0;
  endtask

  task automatic set_ref(input logic [CODE_W-1:0] c, input logic en);
    ref_we_i = 1; ref_code_i = c; ref_en_i = en;
    @(negedge clk_i);
    ref_we_i = 0;
  endtask

  task automatic pop();
    rd_en_i = 1;
    @(negedge clk_i);
    rd_en_i = 0;
  endtask

  // R5 R6 R8: compare head against bench queue, then remove it
  task automatic check_head(input string req);
    logic signed [TS_W-1:0] eofs;
    eofs = $signed(q_ts[q_h] - ref_exp);
    chk(rd_valid_o === 1'b1, req, "valid", longint'(rd_valid_o), 1);
    chk(rd_code_o === q_code[q_h], req, "code", longint'(rd_code_o), longint'(q_code[q_h]));
    chk(rd_ts_o === q_ts[q_h], req, "ts", longint'(rd_ts_o), longint'(q_ts[q_h]));
    chk(rd_ofs_o === eofs, req, "ofs", longint'(rd_ofs_o), longint'(eofs));
    q_h++;
    pop();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(rd_valid_o === 1'b0, "R1", "rd_valid", longint'(rd_valid_o), 0);
    chk(ovf_cnt_o === '0, "R1", "ovf", longint'(ovf_cnt_o), 0);
    chk(ref_seen_o === 1'b0, "R1", "ref_seen", longint'(ref_seen_o), 0);
    rst_ni = 1;
    send(8'h10);
    @(negedge clk_i);
    chk(rd_valid_o === 1'b0, "R1", "mask clear after reset", longint'(rd_valid_o), 0);

    set_mask(8'h10, 1); set_mask(8'h20, 1); set_mask(8'hFF, 1); set_mask(8'h00, 1);
    set_ref(8'h33, 1);

    // R3 R4 R6 R8 vector table
    foreach (VEC[i]) begin
      repeat (int'(VEC[i][7:4])) @(negedge clk_i);
      send(VEC[i][15:8]);
      if (VEC[i][3]) begin q_code[q_n] = VEC[i][15:8]; q_ts[q_n] = last_ts; q_n++; end
      if (VEC[i][2]) ref_exp = last_ts;
    end
    chk(ref_seen_o === 1'b1, "R4", "ref_seen after ref", longint'(ref_seen_o), 1);
    chk(rd_ofs_o < 0, "R6", "oldest record offset negative", longint'(rd_ofs_o), -1);
    while (q_h < q_n) check_head("R8");
    chk(rd_valid_o === 1'b0, "R3", "unmasked codes not stored", longint'(rd_valid_o), 0);

    // R4 disarmed reference neither latches nor stores
    set_ref(8'h33, 0);
    chk(ref_seen_o === 1'b0, "R4", "ref_seen cleared", longint'(ref_seen_o), 0);
    send(8'h33);
    @(negedge clk_i);
    chk(rd_valid_o === 1'b0, "R4", "disarmed ref not stored", longint'(rd_valid_o), 0);
    chk(ref_seen_o === 1'b0, "R4", "disarmed ref no latch", longint'(ref_seen_o), 0);

    // R6 offset equals timestamp without reference
    ref_exp = '0;
    send(8'h20);
    q_code[q_n] = 8'h20; q_ts[q_n] = last_ts; q_n++;
    check_head("R6");

    // R3 clearing a mask bit blocks the code
    set_mask(8'h10, 0);
    send(8'h10);
    @(negedge clk_i);
    chk(rd_valid_o === 1'b0, "R3", "cleared mask bit", longint'(rd_valid_o), 0);
    set_mask(8'h10, 1);

    // R5 read on empty is ignored
    pop(); pop();
    send(8'hFF);
    q_code[q_n] = 8'hFF; q_ts[q_n] = last_ts; q_n++;
    check_head("R5");
    chk(rd_valid_o === 1'b0, "R5", "empty after single pop", longint'(rd_valid_o), 0);

    // R7 overflow
    for (int k = 0; k < 10; k++) send(8'h10);
    chk(ovf_cnt_o === 4'd2, "R7", "two drops", longint'(ovf_cnt_o), 2);
    ev_valid_i = 1; ev_code_i = 8'h20; rd_en_i = 1;
    @(negedge clk_i);
    ev_valid_i = 0; rd_en_i = 0;
    chk(ovf_cnt_o === 4'd3, "R7", "drop with same-cycle read", longint'(ovf_cnt_o), 3);
    send(8'h20);
    for (int k = 0; k < 20; k++) send(8'h10);
    chk(ovf_cnt_o === 4'hF, "R7", "saturation", longint'(ovf_cnt_o), 15);
    begin
      int n = 0;
      logic [CODE_W-1:0] lastc = '0;
      while (rd_valid_o && n < 20) begin lastc = rd_code_o; n++; pop(); end
      chk(n == DEPTH, "R7", "records held at full", n, DEPTH);
      chk(lastc === 8'h20, "R8", "last stored record", longint'(lastc), 32);
    end

    // R2 R6 wrap: reference before wrap, event after
    set_ref(8'h33, 1);
    while (tcyc != 12'd4088) @(negedge clk_i);
    send(8'h33);
    ref_exp = last_ts;
    q_code[q_n] = 8'h33; q_ts[q_n] = last_ts; q_n++;
    while (tcyc != 12'd4) @(negedge clk_i);
    send(8'h10);
    q_code[q_n] = 8'h10; q_ts[q_n] = last_ts; q_n++;
    chk(q_ts[q_n-1] === 12'd4, "R2", "bench wrap point", longint'(q_ts[q_n-1]), 4);
    check_head("R2");
    check_head("R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule